// File: doc/BRIEF.md
# Windowed Frame Scanline Address Sequencer

This block is the per-channel address walker of a frame-oriented DRAM channel. A frame sits in memory as a run of lines spaced by a padded pitch. Software describes a rectangular window inside that frame and, optionally, a point inside the window where the walk begins. On a start pulse the block steps through the window one line at a time. For each line it emits linear burst requests (bank, row, start column, length) to a shared command encoder over a valid/ready handshake.

A line wider than 64 bursts is cut into consecutive requests of at most 64 bursts. When the last request of the last line has been accepted, a one-cycle done pulse fires and the block goes idle. Configuration arrives through a 32-bit register write port decoded by base and mask. A mode write that clears the run bit abandons a frame at once.

Top module: `scanline_seq`

## Requirements
- R1: A write is accepted only when `(wr_addr_i & 0x3F0) == 0x120`. Its offset `wr_addr_i[3:0]` selects the register: 0 mode, 2 frame start, 3 pitch, 4 size (width in bits 12:0, height in bits 31:16), 5 window origin (X in bits 12:0, Y in bits 31:16), 6 start point (X in bits 12:0, Y in bits 31:16). Writes to other bases, and to offsets 1 or 7..15, change nothing.
- R2: Mode bit 0 is run (0 holds the channel in reset), bit 1 is enable, and bit 2 is direction. A `frame_start_i` pulse starts a frame only when run=1, enable=1 and the block is idle; otherwise it is ignored. `req_write_o` carries the direction bit latched at frame start.
- R3: The frame start address (bits 21:0) and the pitch (bits 12:0) are stored with their three lowest bits forced to zero.
- R4: The burst address of a request is `start + (origin_y + y) * pitch + origin_x + x`, taken modulo 2^22. `req_row_o` is address bits 21:7, `req_col_o` is bits 6:0, and `req_bank_o` is always 0.
- R5: A width field of 0 means 8192 bursts, and a height field of 0 means 65536 lines.
- R6: The first line of a frame is window line start_y and begins at window column start_x. Every later line begins at column 0. The walk ends after window line height-1.
- R7: A line segment is issued as requests of 64 bursts each plus one final shorter remainder. Each request starts 64 bursts after the previous one. A length of 64 is encoded as 0 in `req_len_o`.
- R8: While `req_valid_o` is high and `req_ready_i` is low, the request fields and the valid signal hold steady.
- R9: `done_o` is high for exactly the cycle after the final request is accepted, and `busy_o` is low in that cycle.
- R10: If start_x >= width or start_y >= height, a started frame issues no request and `done_o` pulses in the cycle after the start.
- R11: A mode write with bit 0 clear drops `busy_o` and `req_valid_o` in the next cycle without a done pulse. The next frame restarts from the start point.
- R12: Clearing the enable bit during a frame does not stop that frame; it only blocks later starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 10 | Register write address |
| wr_data_i | input | 32 | Register write data |
| frame_start_i | input | 1 | Start-of-frame request pulse |
| req_ready_i | input | 1 | Encoder accepts the current request |
| req_valid_o | output | 1 | Request present |
| req_bank_o | output | 3 | Request bank (always 0) |
| req_row_o | output | 15 | Request row |
| req_col_o | output | 7 | Request start column in 8-word bursts |
| req_len_o | output | 6 | Request length in bursts, 0 means 64 |
| req_write_o | output | 1 | Request direction, 1 = write |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The walk is tried on a small window at the top-left start point, and on a mid-window start point with a stalling consumer. These show whether the first line is treated apart from the rest and whether stalls freeze the request. Wide lines starting off-grid expose the 64-burst split and the 0-means-64 length code. Full-width (width 0) and full-height (height 0) frames tell the maximum encodings apart from truncation. Unaligned address and pitch values, foreign-base writes, empty frames, mid-frame aborts and mid-frame enable clears each isolate one rule of the register and mode handling.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int ROW_W = 15;
  localparam int COL_W = 7;
  localparam int LEN_W = 6;
  localparam int XW    = 13;
  localparam int YW    = 16;
  localparam int BA_W  = ROW_W + COL_W;
  localparam int ALN_W = 3;

  localparam logic [3:0] OFF_MODE  = 4'd0;
  localparam logic [3:0] OFF_START = 4'd2;
  localparam logic [3:0] OFF_PITCH = 4'd3;
  localparam logic [3:0] OFF_SIZE  = 4'd4;
  localparam logic [3:0] OFF_ORG   = 4'd5;
  localparam logic [3:0] OFF_SXY   = 4'd6;

  typedef struct packed {
    logic [BA_W-1:0] base;
    logic [XW-1:0]   pitch;
    logic [XW-1:0]   width;
    logic [YW-1:0]   height;
    logic [XW-1:0]   x0;
    logic [YW-1:0]   y0;
    logic [XW-1:0]   sx;
    logic [YW-1:0]   sy;
  } scan_cfg_t;

  typedef enum logic {S_IDLE, S_REQ} walk_st_e;
endpackage

// File: rtl/scan_regs.sv
module scan_regs
  import scan_pkg::*;
#(
  parameter int              ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE = 10'h120,
  parameter logic [ADDR_W-1:0] MASK = 10'h3f0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic              run_o,
  output logic              en_o,
  output logic              dir_o,
  output logic              abort_o,
  output scan_cfg_t         cfg_o
);
  logic       hit;
  logic [3:0] off;
  logic [2:0] mode_q;
  scan_cfg_t  cfg_q;

  assign hit = wr_en_i && ((wr_addr_i & MASK) == (BASE & MASK));
  assign off = wr_addr_i[3:0];
  assign abort_o = hit && (off == OFF_MODE) && !wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      cfg_q  <= '0;
    end else if (hit) begin
      case (off)
        OFF_MODE:  mode_q <= wr_data_i[2:0];
        OFF_START: cfg_q.base  <= {wr_data_i[BA_W-1:ALN_W], {ALN_W{1'b0}}};
        OFF_PITCH: cfg_q.pitch <= {wr_data_i[XW-1:ALN_W], {ALN_W{1'b0}}};
        OFF_SIZE: begin
          cfg_q.width  <= wr_data_i[XW-1:0];
          cfg_q.height <= wr_data_i[16+YW-1:16];
        end
        OFF_ORG: begin
          cfg_q.x0 <= wr_data_i[XW-1:0];
          cfg_q.y0 <= wr_data_i[16+YW-1:16];
        end
        OFF_SXY: begin
          cfg_q.sx <= wr_data_i[XW-1:0];
          cfg_q.sy <= wr_data_i[16+YW-1:16];
        end
        default: ;
      endcase
    end
  end

  assign run_o = mode_q[0];
  assign en_o  = mode_q[1];
  assign dir_o = mode_q[2];
  assign cfg_o = cfg_q;

  p_abort_clears_run_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !run_o);
endmodule

// File: rtl/scan_walk.sv
module scan_walk
  import scan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic             dir_i,
  input  scan_cfg_t        cfg_i,
  input  logic             req_ready_i,
  output logic             req_valid_o,
  output logic [BA_W-1:0]  req_addr_o,
  output logic [LEN_W-1:0] req_len_o,
  output logic             req_write_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int XC = XW + 1;
  localparam int YC = YW + 1;
  localparam int PW = YC + XW;
  localparam logic [XC-1:0] SEG   = XC'(1 << LEN_W);
  localparam logic [XC-1:0] W_MAX = XC'(1 << XW);
  localparam logic [YC-1:0] H_MAX = YC'(1 << YW);

  walk_st_e        st_q;
  logic [XC-1:0]   x_q, w_q;
  logic [YC-1:0]   y_q, h_q;
  logic [BA_W-1:0] base_q;
  logic [XW-1:0]   x0_q, pitch_q;
  logic            dir_q, done_q;

  logic [XC-1:0]   w_new, rem;
  logic [YC-1:0]   h_new, ys;
  logic [PW-1:0]   prod;
  logic [BA_W-1:0] first_base;
  logic            empty, last_seg, last_line;

  // zero size fields select the largest window
  assign w_new = (cfg_i.width == '0) ? W_MAX : {1'b0, cfg_i.width};
  assign h_new = (cfg_i.height == '0) ? H_MAX : {1'b0, cfg_i.height};
  assign ys    = {1'b0, cfg_i.y0} + {1'b0, cfg_i.sy};
  assign prod  = {{XW{1'b0}}, ys} * {{YC{1'b0}}, cfg_i.pitch};
  assign first_base = cfg_i.base + prod[BA_W-1:0];
  assign empty = ({1'b0, cfg_i.sy} >= h_new) || ({1'b0, cfg_i.sx} >= w_new);

  assign rem       = w_q - x_q;
  assign last_seg  = rem <= SEG;
  assign last_line = y_q == (h_q - YC'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; x_q <= '0; y_q <= '0; base_q <= '0;
      w_q <= '0; h_q <= '0; x0_q <= '0; pitch_q <= '0;
      dir_q <= 1'b0; done_q <= 1'b0;
    end else if (abort_i) begin
      st_q <= S_IDLE; x_q <= '0; y_q <= '0; base_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          if (empty) begin
            done_q <= 1'b1;
          end else begin
            st_q    <= S_REQ;
            x_q     <= {1'b0, cfg_i.sx};
            y_q     <= {1'b0, cfg_i.sy};
            base_q  <= first_base;
            w_q     <= w_new;
            h_q     <= h_new;
            x0_q    <= cfg_i.x0;
            pitch_q <= cfg_i.pitch;
            dir_q   <= dir_i;
          end
        end
        S_REQ: if (req_ready_i) begin
          if (!last_seg) begin
            x_q <= x_q + SEG;
          end else if (last_line) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            x_q    <= '0;
            y_q    <= y_q + YC'(1);
            base_q <= base_q + BA_W'(pitch_q);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_valid_o = (st_q == S_REQ);
  assign req_addr_o  = base_q + BA_W'(x0_q) + BA_W'(x_q);
  assign req_len_o   = last_seg ? rem[LEN_W-1:0] : '0;
  assign req_write_o = dir_q;
  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = done_q;

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i && !abort_i) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(req_len_o) && $stable(req_write_o)));
  p_abort_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && !done_o));
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_valid_o);
endmodule

// File: rtl/scanline_seq.sv
module scanline_seq
  import scan_pkg::*;
#(
  parameter int                ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE   = 10'h120,
  parameter logic [ADDR_W-1:0] MASK   = 10'h3f0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              frame_start_i,
  input  logic              req_ready_i,
  output logic              req_valid_o,
  output logic [2:0]        req_bank_o,
  output logic [ROW_W-1:0]  req_row_o,
  output logic [COL_W-1:0]  req_col_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic              req_write_o,
  output logic              busy_o,
  output logic              done_o
);
  logic            run, en, dir, abort, go;
  scan_cfg_t       cfg;
  logic [BA_W-1:0] addr;

  scan_regs #(.ADDR_W(ADDR_W), .BASE(BASE), .MASK(MASK)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .run_o(run), .en_o(en), .dir_o(dir), .abort_o(abort), .cfg_o(cfg)
  );

  assign go = frame_start_i && run && en;

  scan_walk u_walk (
    .clk_i, .rst_ni, .abort_i(abort), .start_i(go), .dir_i(dir), .cfg_i(cfg),
    .req_ready_i, .req_valid_o, .req_addr_o(addr), .req_len_o,
    .req_write_o, .busy_o, .done_o
  );

  assign req_row_o  = addr[BA_W-1:COL_W];
  assign req_col_o  = addr[COL_W-1:0];
  assign req_bank_o = '0;

  p_reset_blocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !busy_o);
  p_start_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(run && en && frame_start_i));
endmodule

// File: tb/scanline_seq_bench.sv
`timescale 1ns/1ps
module scanline_seq_bench;
  localparam int BASE = 'h120;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        wr_en = 1'b0, start = 1'b0, ready = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        valid, wdir, busy, done;
  logic [2:0]  bank;
  logic [14:0] row;
  logic [6:0]  col;
  logic [5:0]  len;
  int total = 0, bad = 0, cycles = 0;
  longint m_sa, m_pitch, m_w, m_h, m_x0, m_y0, m_sx, m_sy;

  always #2.5 clk = ~clk;

  scanline_seq u_scanline_seq (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .frame_start_i(start), .req_ready_i(ready), .req_valid_o(valid),
    .req_bank_o(bank), .req_row_o(row), .req_col_o(col), .req_len_o(len),
    .req_write_o(wdir), .busy_o(busy), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 10'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input longint sa, pitch, w, h, x0, y0, sx, sy);
    wr(BASE + 2, 32'(sa));
    wr(BASE + 3, 32'(pitch));
    wr(BASE + 4, {16'(h), 3'b0, 13'(w)});
    wr(BASE + 5, {16'(y0), 3'b0, 13'(x0)});
    wr(BASE + 6, {16'(sy), 3'b0, 13'(sx)});
    m_sa = sa & 64'h3ffff8; m_pitch = pitch & 64'h1ff8;
    m_w = (w == 0) ? 8192 : w; m_h = (h == 0) ? 65536 : h;
    m_x0 = x0; m_y0 = y0; m_sx = sx; m_sy = sy;
  endtask

  // act_at: accepted-request count at which act_data is written to the mode register
  task automatic run(input bit stall, input int act_at, input logic [31:0] act_data,
                     input bit exp_wr, input string tag);
    longint ex, ey, a, l;
    int got, cyc;
    bit exhausted, aborting, pend_abort, acted, prev_stall, fin;
    logic [14:0] p_row; logic [6:0] p_col; logic [5:0] p_len;
    ex = m_sx; ey = m_sy; got = 0; cyc = 0;
    exhausted = (m_sy >= m_h) || (m_sx >= m_w);
    aborting = 0; pend_abort = 0; acted = 0; prev_stall = 0; fin = 0;
    p_row = '0; p_col = '0; p_len = '0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!fin && cyc < 190000) begin
      wr_en = 1'b0;
      if (aborting) begin
        check(!busy && !valid && !done, "R11 abort idle", {busy, valid, done}, 0);
        repeat (3) @(negedge clk);
        check(!busy && !done && !valid, "R11 stays idle", {busy, valid, done}, 0);
        fin = 1;
      end else if (done) begin
        check(exhausted, {"R9 done after last ", tag}, got, got);
        check(!busy && !valid, "R9 idle with done", {busy, valid}, 0);
        @(negedge clk);
        check(!done, "R9 single pulse", done, 0);
        fin = 1;
      end else begin
        if (valid) begin
          if (exhausted) check(0, {"R6 extra request ", tag}, {row, col}, 0);
          else begin
            a = (m_sa + (m_y0 + ey) * m_pitch + m_x0 + ex) % (64'd1 << 22);
            l = m_w - ex; if (l > 64) l = 64;
            check({row, col} == 22'(a), {"R4 address ", tag}, {row, col}, a);
            check(len == 6'(l % 64), {"R7 length ", tag}, len, l % 64);
            check(bank == 3'd0 && wdir == exp_wr, "R2 bank/dir", {bank, wdir}, {3'd0, exp_wr});
          end
          if (prev_stall)
            check(row == p_row && col == p_col && len == p_len, "R8 hold",
                  {row, col, len}, {p_row, p_col, p_len});
        end else if (prev_stall) check(0, "R8 valid dropped", 0, 1);
        ready = !(stall && (cyc % 3 == 1));
        prev_stall = valid && !ready;
        p_row = row; p_col = col; p_len = len;
        if (valid && ready && !exhausted) begin
          l = m_w - ex; if (l > 64) l = 64;
          ex += l; got++;
          if (ex >= m_w) begin ex = 0; ey++; if (ey >= m_h) exhausted = 1; end
        end
        if (!acted && act_at >= 0 && got == act_at) begin
          acted = 1; wr_en = 1'b1; wr_addr = 10'(BASE); wr_data = act_data;
          if (!act_data[0]) pend_abort = 1;
        end
        @(negedge clk); cyc++;
        aborting = pend_abort;
      end
    end
    wr_en = 1'b0; ready = 1'b0;
    if (!fin) check(0, {"R9 frame never ended ", tag}, cyc, 0);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 195000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<195000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !valid && !done, "R2 reset state", {busy, valid, done}, 0);
    rst_ni = 1'b1;
    // R2: reset-held or disabled channel ignores start
    setup(64, 16, 5, 3, 2, 1, 0, 0);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !valid, "R2 start while in reset", busy, 0);
    wr(BASE, 32'h1);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !valid, "R2 start while disabled", busy, 0);
    wr(BASE, 32'h3);
    run(0, -1, 0, 0, "small window");               // R4 R6
    wr(BASE, 32'h7);
    setup(64, 16, 7, 4, 3, 2, 4, 1);
    run(1, -1, 0, 1, "mid start stalls");           // R6 R8 R2
    wr(BASE, 32'h3);
    setup('h45, 'h13, 6, 3, 1, 2, 0, 0);
    run(0, -1, 0, 0, "unaligned R3");               // R3
    setup('h1000, 160, 150, 2, 5, 3, 10, 0);
    run(1, -1, 0, 0, "split R7");                   // R7
    setup(0, 8184, 0, 2, 0, 0, 0, 0);
    run(0, -1, 0, 0, "width0 R5");                  // R5
    setup(8, 64, 4, 5, 0, 0, 0, 5);
    run(0, -1, 0, 0, "empty y R10");                // R10
    setup(8, 64, 4, 5, 0, 0, 4, 0);
    run(0, -1, 0, 0, "empty x R10");
    // R1: foreign base and unused offsets do not alter registers
    setup(256, 32, 4, 2, 1, 1, 0, 0);
    wr('h130 + 4, 32'h0003_0009);
    wr(BASE + 7, 32'hffff_ffff);
    wr(BASE + 1, 32'hffff_ffff);
    wr('h320 + 4, 32'h0005_0011);
    run(0, -1, 0, 0, "decode R1");
    // R11 abort then fresh restart
    setup(512, 128, 20, 10, 2, 2, 3, 1);
    run(0, 5, 32'h0, 0, "abort R11");
    wr(BASE, 32'h3);
    run(1, -1, 0, 0, "restart R11");
    // R12 enable cleared mid-frame
    run(1, 4, 32'h1, 0, "enable clear R12");
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy, "R12 later start blocked", busy, 0);
    wr(BASE, 32'h3);
    setup(0, 8, 64, 0, 0, 0, 0, 0);
    run(0, -1, 0, 0, "height0 R5");                 // R5
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule